// File: doc/BRIEF.md
# Legacy Divisor-Access Fallback Controller

This block sits beside a banked serial-port register file and owns the mode state of the port: whether the extended register set is active, which operating mode (wired UART, two slow infrared modes, two fast infrared modes and a consumer remote-control mode) is selected, the FIFO depth, the baud prescaler select, two test/loopback bits and a lock bit. Software reaches this state through a bank-select value, a 3-bit address, single-cycle read and write strobes and an 8-bit data path.

Old drivers know nothing of the extended features. They program the baud divisor through the legacy bank (bank 1), so any access to the divisor there is taken as a sign of legacy software, and the block falls back to a plain compatible setup. The same divisor can be reached through alternate ports in bank 2 with no side effects. When the lock bit is set and the port is not in extended mode, legacy divisor accesses go to two scratch bytes, so that the real divisor and the mode state are shielded.

Top module: `uart_fallback_ctl`

## Requirements
- R1: After reset: extended mode off, operating mode 0 (UART), FIFO depth 16 (`fifo_deep`=0), prescaler code 0 (divide by 13), test bits 00, lock 0, divisor 16'h0001.
- R2: Bank 2, address 0 (low byte) and address 1 (high byte) read and write the divisor and never change the mode state.
- R3: Bank 2 address 2 is the mode register (bit 0 extended, bits 3:1 operating mode, bit 4 FIFO depth 32); bank 2 address 4 is the auxiliary register (bits 1:0 prescaler code, bits 3:2 test bits, bit 7 lock); both read back what was written.
- R4: A read or write of bank 1 address 0 or 1 while extended mode is on sets FIFO depth 16, prescaler code 0, test bits 00, operating mode 0 and turns extended mode off; a write also updates the addressed divisor byte.
- R5: The same access in non-extended mode with lock clear sets FIFO depth 16, prescaler code 0, test bits 00 and forces operating mode 0 unless the mode is 1 or 2.
- R6: A non-extended fallback leaves operating mode 1 or 2 (the slow infrared modes) unchanged.
- R7: With lock set in non-extended mode, bank 1 addresses 0 and 1 read and write two scratch bytes; divisor and mode state stay unchanged.
- R8: In extended mode the lock bit does not block a fallback; the lock bit itself is kept.
- R9: A fallback takes effect at the clock edge ending the access; read data during a triggering read shows the state before the fallback.
- R10: Accesses to any other bank/address combination change no state and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 3 | Selected register bank |
| addr | input | 3 | Register address within the bank |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from current state |
| ext_mode | output | 1 | Extended register set active |
| op_mode | output | 3 | Operating mode code |
| fifo_deep | output | 1 | 1 selects 32-level FIFOs, 0 selects 16 |
| presc_sel | output | 2 | Prescaler code, 0 is divide by 13 |
| test_bits | output | 2 | Test/loopback controls |
| lock | output | 1 | Legacy divisor lock |
| divisor | output | 16 | Baud divisor |

## Verification
The bench aims at the accesses whose side effects differ only by mode: a bank 2 divisor write in extended mode (a design that decoded the bank loosely would drop out of extended mode), a legacy access with a slow infrared mode selected (a wrong design forces UART), and a locked legacy write (a wrong design overwrites the divisor or falls back). It also sets lock in extended mode and checks that the fallback still occurs, and reads the divisor through bank 1 so that a design updating state too early would return post-fallback data.

// File: rtl/uart_fallback_ctl.sv
module uart_fallback_ctl #(
  parameter logic [15:0] DIV_RESET = 16'h0001,
  parameter logic [2:0]  LEGACY_BANK = 3'd1,
  parameter logic [2:0]  ALT_BANK = 3'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bank_sel,
  input  logic [2:0]  addr,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  output logic        ext_mode,
  output logic [2:0]  op_mode,
  output logic        fifo_deep,
  output logic [1:0]  presc_sel,
  output logic [1:0]  test_bits,
  output logic        lock,
  output logic [15:0] divisor
);
  localparam logic [2:0] MODE_UART = 3'd0;
  localparam logic [2:0] A_MODE = 3'd2;
  localparam logic [2:0] A_AUX  = 3'd4;

  logic [15:0] scratch;

  wire div_addr  = (addr[2:1] == 2'b00);
  wire in_legacy = (bank_sel == LEGACY_BANK) && div_addr;
  wire in_alt    = (bank_sel == ALT_BANK) && div_addr;
  wire shadowed  = lock && !ext_mode;
  wire legacy_hit = in_legacy && (rd_en || wr_en);
  wire fallback  = legacy_hit && !shadowed;
  wire slow_ir   = (op_mode == 3'd1) || (op_mode == 3'd2);
  wire wr_mode   = wr_en && (bank_sel == ALT_BANK) && (addr == A_MODE);
  wire wr_aux    = wr_en && (bank_sel == ALT_BANK) && (addr == A_AUX);
  wire wr_div    = wr_en && (in_alt || (in_legacy && !shadowed));
  wire wr_scr    = wr_en && in_legacy && shadowed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divisor <= DIV_RESET;
      scratch <= '0;
    end else begin
      if (wr_div) begin
        if (addr[0]) divisor[15:8] <= wr_data;
        else         divisor[7:0]  <= wr_data;
      end
      if (wr_scr) begin
        if (addr[0]) scratch[15:8] <= wr_data;
        else         scratch[7:0]  <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_mode  <= 1'b0;
      op_mode   <= MODE_UART;
      fifo_deep <= 1'b0;
    end else if (wr_mode) begin
      ext_mode  <= wr_data[0];
      op_mode   <= wr_data[3:1];
      fifo_deep <= wr_data[4];
    end else if (fallback) begin
      fifo_deep <= 1'b0;
      if (ext_mode) begin
        ext_mode <= 1'b0;
        op_mode  <= MODE_UART;
      end else if (!slow_ir) begin
        op_mode  <= MODE_UART;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_sel <= 2'b00;
      test_bits <= 2'b00;
      lock      <= 1'b0;
    end else if (wr_aux) begin
      presc_sel <= wr_data[1:0];
      test_bits <= wr_data[3:2];
      lock      <= wr_data[7];
    end else if (fallback) begin
      presc_sel <= 2'b00;
      test_bits <= 2'b00;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (in_legacy && shadowed)
      rd_data = addr[0] ? scratch[15:8] : scratch[7:0];
    else if (in_legacy || in_alt)
      rd_data = addr[0] ? divisor[15:8] : divisor[7:0];
    else if (bank_sel == ALT_BANK && addr == A_MODE)
      rd_data = {3'b000, fifo_deep, op_mode, ext_mode};
    else if (bank_sel == ALT_BANK && addr == A_AUX)
      rd_data = {lock, 3'b000, test_bits, presc_sel};
  end
endmodule

module uart_fallback_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bank_sel,
  input logic [2:0]  addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic        ext_mode,
  input logic [2:0]  op_mode,
  input logic        fifo_deep,
  input logic [1:0]  presc_sel,
  input logic [1:0]  test_bits,
  input logic        lock,
  input logic [15:0] divisor
);
  wire acc  = rd_en || wr_en;
  wire divp = (addr[2:1] == 2'b00);
  wire leg  = acc && divp && bank_sel == 3'd1;
  wire alt  = acc && divp && bank_sel == 3'd2;

  a_r2_alt_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    alt |=> (ext_mode == $past(ext_mode)) && (op_mode == $past(op_mode)) && (fifo_deep == $past(fifo_deep)));

  a_r4_ext_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    leg && ext_mode |=> !ext_mode && op_mode == 3'd0 && !fifo_deep && presc_sel == 2'b00 && test_bits == 2'b00);

  a_r6_slow_ir_kept: assert property (@(posedge clk) disable iff (!rst_n)
    leg && !ext_mode && !lock && (op_mode == 3'd1 || op_mode == 3'd2) |=> op_mode == $past(op_mode));

  a_r7_lock_shields: assert property (@(posedge clk) disable iff (!rst_n)
    leg && !ext_mode && lock |=> divisor == $past(divisor) && presc_sel == $past(presc_sel) && test_bits == $past(test_bits));

  a_r8_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
    leg && ext_mode && lock |=> lock && !ext_mode);
endmodule

bind uart_fallback_ctl uart_fallback_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .ext_mode(ext_mode), .op_mode(op_mode), .fifo_deep(fifo_deep), .presc_sel(presc_sel),
  .test_bits(test_bits), .lock(lock), .divisor(divisor)
);

// File: tb/uart_fallback_ctl_test.sv
module uart_fallback_ctl_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] bank_sel = 0, addr = 0;
  logic rd_en = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic ext_mode, fifo_deep, lock;
  logic [2:0] op_mode;
  logic [1:0] presc_sel, test_bits;
  logic [15:0] divisor;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  uart_fallback_ctl uut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ext_mode(ext_mode), .op_mode(op_mode),
    .fifo_deep(fifo_deep), .presc_sel(presc_sel), .test_bits(test_bits), .lock(lock), .divisor(divisor)
  );

  function automatic logic [26:0] st(input logic e, input logic [2:0] m, input logic d,
                                     input logic [1:0] p, input logic [1:0] t, input logic l,
                                     input logic [15:0] dv);
    return {e, m, d, p, t, l, dv};
  endfunction

  wire [26:0] cur = {ext_mode, op_mode, fifo_deep, presc_sel, test_bits, lock, divisor};

  // fields: bank, addr, rd, wr, data, expected read (checked when rd), expected state after
  localparam int N = 18;
  localparam logic [50:0] VEC [N] = '{
    {3'd2, 3'd0, 1'b0, 1'b1, 8'h34, 8'h00, st(0, 3'd0, 0, 2'd0, 2'd0, 0, 16'h0034)}, // R2
    {3'd2, 3'd2, 1'b0, 1'b1, 8'h1B, 8'h00, st(1, 3'd5, 1, 2'd0, 2'd0, 0, 16'h0034)}, // R3
    {3'd2, 3'd4, 1'b0, 1'b1, 8'h8D, 8'h00, st(1, 3'd5, 1, 2'd1, 2'd3, 1, 16'h0034)}, // R3
    {3'd2, 3'd4, 1'b1, 1'b0, 8'h00, 8'h8D, st(1, 3'd5, 1, 2'd1, 2'd3, 1, 16'h0034)}, // R3
    {3'd1, 3'd1, 1'b1, 1'b0, 8'h00, 8'h00, st(0, 3'd0, 0, 2'd0, 2'd0, 1, 16'h0034)}, // R4 R8 R9
    {3'd1, 3'd0, 1'b0, 1'b1, 8'h77, 8'h00, st(0, 3'd0, 0, 2'd0, 2'd0, 1, 16'h0034)}, // R7
    {3'd1, 3'd0, 1'b1, 1'b0, 8'h00, 8'h77, st(0, 3'd0, 0, 2'd0, 2'd0, 1, 16'h0034)}, // R7
    {3'd2, 3'd4, 1'b0, 1'b1, 8'h0E, 8'h00, st(0, 3'd0, 0, 2'd2, 2'd3, 0, 16'h0034)}, // R3
    {3'd2, 3'd2, 1'b0, 1'b1, 8'h14, 8'h00, st(0, 3'd2, 1, 2'd2, 2'd3, 0, 16'h0034)}, // R3
    {3'd1, 3'd1, 1'b0, 1'b1, 8'h12, 8'h00, st(0, 3'd2, 0, 2'd0, 2'd0, 0, 16'h1234)}, // R5 R6
    {3'd2, 3'd2, 1'b0, 1'b1, 8'h1A, 8'h00, st(0, 3'd5, 1, 2'd0, 2'd0, 0, 16'h1234)}, // R3
    {3'd2, 3'd4, 1'b0, 1'b1, 8'h06, 8'h00, st(0, 3'd5, 1, 2'd2, 2'd1, 0, 16'h1234)}, // R3
    {3'd1, 3'd0, 1'b0, 1'b1, 8'h56, 8'h00, st(0, 3'd0, 0, 2'd0, 2'd0, 0, 16'h1256)}, // R5
    {3'd2, 3'd2, 1'b0, 1'b1, 8'h13, 8'h00, st(1, 3'd1, 1, 2'd0, 2'd0, 0, 16'h1256)}, // R3
    {3'd2, 3'd1, 1'b0, 1'b1, 8'h99, 8'h00, st(1, 3'd1, 1, 2'd0, 2'd0, 0, 16'h9956)}, // R2
    {3'd1, 3'd0, 1'b1, 1'b0, 8'h00, 8'h56, st(0, 3'd0, 0, 2'd0, 2'd0, 0, 16'h9956)}, // R4 R9
    {3'd3, 3'd0, 1'b0, 1'b1, 8'hFF, 8'h00, st(0, 3'd0, 0, 2'd0, 2'd0, 0, 16'h9956)}, // R10
    {3'd1, 3'd6, 1'b1, 1'b0, 8'h00, 8'h00, st(0, 3'd0, 0, 2'd0, 2'd0, 0, 16'h9956)}  // R10
  };

  task automatic check(input string req, input logic [26:0] act, input logic [26:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [2:0] b, input logic [2:0] a, input logic r, input logic w,
                        input logic [7:0] d, input string req, input logic [7:0] exp_rd);
    @(negedge clk);
    bank_sel = b; addr = a; rd_en = r; wr_en = w; wr_data = d;
    #1;
    if (r) check(req, {19'd0, rd_data}, {19'd0, exp_rd});
    @(negedge clk);
    rd_en = 0; wr_en = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state", cur, st(0, 3'd0, 0, 2'd0, 2'd0, 0, 16'h0001));
    for (int i = 0; i < N; i++) begin
      access(VEC[i][50:48], VEC[i][47:45], VEC[i][44], VEC[i][43], VEC[i][42:35],
             $sformatf("R2-R10 vector %0d read", i), VEC[i][34:27]);
      check($sformatf("vector %0d state (R2 R4 R5 R6 R7 R10)", i), cur, VEC[i][26:0]);
    end
    // R8: lock set while extended, legacy write still falls back and writes divisor
    access(3'd2, 3'd2, 0, 1, 8'h01, "R8 setup", 8'h00);
    access(3'd2, 3'd4, 0, 1, 8'h80, "R8 setup", 8'h00);
    access(3'd1, 3'd0, 0, 1, 8'hAA, "R8 write", 8'h00);
    check("R8 ext overrides lock", cur, st(0, 3'd0, 0, 2'd0, 2'd0, 1, 16'h99AA));
    // R9: state unchanged during the access cycle, updated right after the edge
    access(3'd2, 3'd2, 0, 1, 8'h1F, "R9 setup", 8'h00);
    @(negedge clk);
    bank_sel = 3'd1; addr = 3'd1; rd_en = 1;
    #1;
    check("R9 before edge", {26'd0, ext_mode}, 27'd1);
    check("R9 read data pre-fallback", {19'd0, rd_data}, 27'h99);
    @(posedge clk); #1;
    rd_en = 0;
    check("R9 after edge", {26'd0, ext_mode}, 27'd0);
    // R1: reset again from a busy state
    access(3'd2, 3'd4, 0, 1, 8'h8F, "R1 setup", 8'h00);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 reset after use", cur, st(0, 3'd0, 0, 2'd0, 2'd0, 0, 16'h0001));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule